// File: doc/BRIEF.md
# Even/Odd Dual-Issue Pairing Logic

This block sits at the issue stage of an in-order SIMD core. Every cycle it looks at the two oldest fetched instructions, called slot A and slot B. For each one it is given the word address, the opcode, one destination register and up to three source registers, each source with its own enable bit. It decides how many of them leave the window that cycle: none, slot A alone, or both together. It reports that count to the fetch side, which advances its window by the same amount.

The core has two pipe groups, even and odd, and every opcode belongs to one of them. A small lookup gives each opcode its pipe and its result latency. The two slots leave together only under four conditions. Slot A must sit at an even word address and use the even pipe. Slot B must sit at an odd word address and use the odd pipe. Slot B must not depend on slot A. Neither slot may touch a register that is still being produced by an earlier instruction. In every other case the pair is serialised. A per-register scoreboard counts down the latency of every instruction in flight. A downstream stall freezes the issue registers and the window without losing anything.

The issued instructions come out on two registered ports, one per pipe. Each port carries a valid strobe, the opcode, the destination register and the word address.

Top module: `dual_issue_pair`

## Requirements
- R1: While `rst` is high, both issue strobes go low on the next clock edge, `adv_o` is 0 and every scoreboard entry is cleared.
- R2: Both slots issue in one cycle when all of these hold: slot A is at an even address with opcode bit 3 = 0 (even pipe), slot B is at an odd address with opcode bit 3 = 1 (odd pipe), there are no dependences and nothing is pending. In that case `adv_o` = 2, and on the next cycle the even port carries slot A and the odd port carries slot B.
- R3: If slot A is at an even address but the pipe classes are not even-then-odd, only slot A issues (`adv_o` = 1).
- R4: If slot A is at an odd address, it issues alone (`adv_o` = 1). The next window then starts at the following even address.
- R5: Slot B does not issue alongside slot A in two cases: any enabled source of slot B equals slot A's destination, or both slots name the same destination.
- R6: An instruction with latency L blocks, through the scoreboard, any later instruction that has an enabled source equal to its destination. The block lasts for the L cycles that follow its issue cycle. Sources whose enable bit is 0 are never checked.
- R7: An instruction whose destination register still has a nonzero scoreboard count does not issue.
- R8: While `stall_i` is high, `adv_o` is 0, the issue outputs keep their values and the scoreboard counts keep decreasing.
- R9: Class lookup: the pipe is opcode bit 3 (0 = even, 1 = odd) and the latency is 2 + opcode[1:0]. An instruction that issues alone appears only on the port of its own pipe.
- R10: Instructions leave strictly in program order and at most two per cycle. Slot B never issues without slot A, and every instruction in the stream is issued exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Downstream stall; freezes issue |
| a_vld_i | input | 1 | Slot A holds an instruction |
| a_addr_i | input | AW | Word address of slot A |
| a_opc_i | input | 4 | Opcode of slot A |
| a_dst_i | input | RW | Destination register of slot A |
| a_src_i | input | 3*RW | Three source registers of slot A, source k at bits k*RW |
| a_sen_i | input | 3 | Source enables of slot A |
| b_vld_i | input | 1 | Slot B holds an instruction |
| b_addr_i | input | AW | Word address of slot B |
| b_opc_i | input | 4 | Opcode of slot B |
| b_dst_i | input | RW | Destination register of slot B |
| b_src_i | input | 3*RW | Three source registers of slot B |
| b_sen_i | input | 3 | Source enables of slot B |
| adv_o | output | 2 | Number of slots consumed this cycle (0, 1 or 2) |
| ev_vld_o | output | 1 | Even pipe issue strobe |
| ev_opc_o | output | 4 | Opcode sent to the even pipe |
| ev_dst_o | output | RW | Destination sent to the even pipe |
| ev_addr_o | output | AW | Address of the even pipe instruction |
| od_vld_o | output | 1 | Odd pipe issue strobe |
| od_opc_o | output | 4 | Opcode sent to the odd pipe |
| od_dst_o | output | RW | Destination sent to the odd pipe |
| od_addr_o | output | AW | Address of the odd pipe instruction |

## Verification
The stream fed to the block includes the following cases:
- Aligned even-then-odd pairs with no dependences. These separate a true dual issue from a block that serialises everything.
- Pairs that fail only on pipe class, and windows that start at an odd address. These show that the parity test and the class test are made separately.
- Pairs linked by a read-after-write or by a shared destination. A read through a disabled source field must not block, which shows that the enable bits are honoured.
- Producers of every latency followed by their readers. These measure the exact number of blocked cycles.
- Stall pulses landing in the middle of a dependence wait. These show that outputs hold while the scoreboard keeps counting down.

// File: rtl/dip_pkg.sv
package dip_pkg;
  localparam int OPC_W = 4;
  localparam int LAT_W = 3;

  typedef enum logic {
    PIPE_EVEN = 1'b0,
    PIPE_ODD  = 1'b1
  } pipe_e;

  // class table: top opcode bit picks the pipe, low two bits add latency
  function automatic pipe_e pipe_of(input logic [OPC_W-1:0] opc);
    return pipe_e'(opc[OPC_W-1]);
  endfunction

  function automatic logic [LAT_W-1:0] lat_of(input logic [OPC_W-1:0] opc);
    return LAT_W'(2) + LAT_W'(opc[1:0]);
  endfunction
endpackage

// File: rtl/dip_class.sv
module dip_class
  import dip_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output pipe_e            pipe_o,
  output logic [LAT_W-1:0] lat_o
);
  assign pipe_o = pipe_of(opc_i);
  assign lat_o  = lat_of(opc_i);
endmodule

// File: rtl/dip_scoreboard.sv
module dip_scoreboard
  import dip_pkg::*;
#(
  parameter int NREG = 32,
  parameter int NQ   = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NQ*RW-1:0]  q_reg_i,
  output logic [NQ-1:0]     q_busy_o,
  input  logic [1:0]        set_en_i,
  input  logic [2*RW-1:0]   set_reg_i,
  input  logic [2*LAT_W-1:0] set_lat_i
);
  logic [LAT_W-1:0] cnt_q [NREG];

  logic [RW-1:0]    set_r0, set_r1;
  logic [LAT_W-1:0] set_l0, set_l1;
  assign set_r0 = set_reg_i[RW-1:0];
  assign set_r1 = set_reg_i[2*RW-1:RW];
  assign set_l0 = set_lat_i[LAT_W-1:0];
  assign set_l1 = set_lat_i[2*LAT_W-1:LAT_W];

  for (genvar r = 0; r < NREG; r++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[r] <= '0;
      end else if (set_en_i[0] && set_r0 == RW'(r)) begin
        cnt_q[r] <= set_l0;
      end else if (set_en_i[1] && set_r1 == RW'(r)) begin
        cnt_q[r] <= set_l1;
      end else if (cnt_q[r] != '0) begin
        cnt_q[r] <= cnt_q[r] - LAT_W'(1);
      end
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_query
    assign q_busy_o[q] = (cnt_q[q_reg_i[q*RW +: RW]] != '0);
  end

  // R7: a register is only claimed once its previous producer has drained
  p_claim_idle_r7: assert property (@(posedge clk) disable iff (rst)
    set_en_i[0] |-> cnt_q[set_r0] == '0);
  p_claim_idle_b_r7: assert property (@(posedge clk) disable iff (rst)
    set_en_i[1] |-> cnt_q[set_r1] == '0);
  // R5: a pair never claims the same register twice
  p_pair_distinct_r5: assert property (@(posedge clk) disable iff (rst)
    (set_en_i[0] && set_en_i[1]) |-> set_r0 != set_r1);
  // R1: scoreboard empty right after reset
  p_clear_r1: assert property (@(posedge clk)
    rst |=> cnt_q[0] == '0);
endmodule

// File: rtl/dip_pair_decide.sv
module dip_pair_decide
  import dip_pkg::*;
#(
  parameter int AW = 12,
  parameter int RW = 5
) (
  input  logic          hold_i,
  input  logic          a_vld_i,
  input  logic [AW-1:0] a_addr_i,
  input  pipe_e         a_pipe_i,
  input  logic [RW-1:0] a_dst_i,
  input  logic [2:0]    a_sen_i,
  input  logic [2:0]    a_src_busy_i,
  input  logic          a_dst_busy_i,
  input  logic          b_vld_i,
  input  logic [AW-1:0] b_addr_i,
  input  pipe_e         b_pipe_i,
  input  logic [RW-1:0] b_dst_i,
  input  logic [3*RW-1:0] b_src_i,
  input  logic [2:0]    b_sen_i,
  input  logic [2:0]    b_src_busy_i,
  input  logic          b_dst_busy_i,
  output logic          issue_a_o,
  output logic          issue_b_o,
  output logic [1:0]    adv_o
);
  logic [2:0] raw;
  for (genvar k = 0; k < 3; k++) begin : g_raw
    assign raw[k] = b_sen_i[k] && (b_src_i[k*RW +: RW] == a_dst_i);
  end

  logic a_blocked, b_blocked, slot_ok, indep;

  always_comb begin
    a_blocked = (|(a_src_busy_i & a_sen_i)) || a_dst_busy_i;
    b_blocked = (|(b_src_busy_i & b_sen_i)) || b_dst_busy_i;
    slot_ok   = !a_addr_i[0] && (a_pipe_i == PIPE_EVEN) &&
                 b_addr_i[0] && (b_pipe_i == PIPE_ODD);
    indep     = !(|raw) && (b_dst_i != a_dst_i);
    issue_a_o = !hold_i && a_vld_i && !a_blocked;
    issue_b_o = issue_a_o && b_vld_i && slot_ok && indep && !b_blocked;
    adv_o     = {issue_b_o, issue_a_o & ~issue_b_o};
  end
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dip_pkg::*;
#(
  parameter int AW   = 12,
  parameter int NREG = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic              a_vld_i,
  input  logic [AW-1:0]     a_addr_i,
  input  logic [OPC_W-1:0]  a_opc_i,
  input  logic [RW-1:0]     a_dst_i,
  input  logic [3*RW-1:0]   a_src_i,
  input  logic [2:0]        a_sen_i,
  input  logic              b_vld_i,
  input  logic [AW-1:0]     b_addr_i,
  input  logic [OPC_W-1:0]  b_opc_i,
  input  logic [RW-1:0]     b_dst_i,
  input  logic [3*RW-1:0]   b_src_i,
  input  logic [2:0]        b_sen_i,
  output logic [1:0]        adv_o,
  output logic              ev_vld_o,
  output logic [OPC_W-1:0]  ev_opc_o,
  output logic [RW-1:0]     ev_dst_o,
  output logic [AW-1:0]     ev_addr_o,
  output logic              od_vld_o,
  output logic [OPC_W-1:0]  od_opc_o,
  output logic [RW-1:0]     od_dst_o,
  output logic [AW-1:0]     od_addr_o
);
  localparam int NSLOT = 2;
  localparam int NQ    = NSLOT * 4;

  logic [OPC_W-1:0] slot_opc [NSLOT];
  pipe_e            slot_pipe [NSLOT];
  logic [LAT_W-1:0] slot_lat [NSLOT];
  assign slot_opc[0] = a_opc_i;
  assign slot_opc[1] = b_opc_i;

  for (genvar s = 0; s < NSLOT; s++) begin : g_cls
    dip_class i_cls (
      .opc_i (slot_opc[s]),
      .pipe_o(slot_pipe[s]),
      .lat_o (slot_lat[s])
    );
  end

  // query order: A src0..2, A dst, B src0..2, B dst
  logic [NQ*RW-1:0] q_reg;
  logic [NQ-1:0]    q_busy;
  assign q_reg = {b_dst_i, b_src_i, a_dst_i, a_src_i};

  logic       issue_a, issue_b;
  logic [1:0] adv;

  dip_scoreboard #(.NREG(NREG), .NQ(NQ)) i_sb (
    .clk      (clk),
    .rst      (rst),
    .q_reg_i  (q_reg),
    .q_busy_o (q_busy),
    .set_en_i ({issue_b, issue_a}),
    .set_reg_i({b_dst_i, a_dst_i}),
    .set_lat_i({slot_lat[1], slot_lat[0]})
  );

  dip_pair_decide #(.AW(AW), .RW(RW)) i_dec (
    .hold_i      (stall_i | rst),
    .a_vld_i     (a_vld_i),
    .a_addr_i    (a_addr_i),
    .a_pipe_i    (slot_pipe[0]),
    .a_dst_i     (a_dst_i),
    .a_sen_i     (a_sen_i),
    .a_src_busy_i(q_busy[2:0]),
    .a_dst_busy_i(q_busy[3]),
    .b_vld_i     (b_vld_i),
    .b_addr_i    (b_addr_i),
    .b_pipe_i    (slot_pipe[1]),
    .b_dst_i     (b_dst_i),
    .b_src_i     (b_src_i),
    .b_sen_i     (b_sen_i),
    .b_src_busy_i(q_busy[6:4]),
    .b_dst_busy_i(q_busy[7]),
    .issue_a_o   (issue_a),
    .issue_b_o   (issue_b),
    .adv_o       (adv)
  );

  assign adv_o = adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_vld_o  <= 1'b0;
      ev_opc_o  <= '0;
      ev_dst_o  <= '0;
      ev_addr_o <= '0;
      od_vld_o  <= 1'b0;
      od_opc_o  <= '0;
      od_dst_o  <= '0;
      od_addr_o <= '0;
    end else if (!stall_i) begin
      ev_vld_o <= 1'b0;
      od_vld_o <= 1'b0;
      if (issue_b) begin
        ev_vld_o  <= 1'b1;
        ev_opc_o  <= a_opc_i;
        ev_dst_o  <= a_dst_i;
        ev_addr_o <= a_addr_i;
        od_vld_o  <= 1'b1;
        od_opc_o  <= b_opc_i;
        od_dst_o  <= b_dst_i;
        od_addr_o <= b_addr_i;
      end else if (issue_a) begin
        if (slot_pipe[0] == PIPE_ODD) begin
          od_vld_o  <= 1'b1;
          od_opc_o  <= a_opc_i;
          od_dst_o  <= a_dst_i;
          od_addr_o <= a_addr_i;
        end else begin
          ev_vld_o  <= 1'b1;
          ev_opc_o  <= a_opc_i;
          ev_dst_o  <= a_dst_i;
          ev_addr_o <= a_addr_i;
        end
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!ev_vld_o && !od_vld_o));
  p_pair_parity_r3: assert property (@(posedge clk) disable iff (rst)
    (ev_vld_o && od_vld_o) |-> (!ev_addr_o[0] && od_addr_o[0]));
  p_stall_noadv_r8: assert property (@(posedge clk) disable iff (rst)
    stall_i |-> adv_o == 2'd0);
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> ($stable(ev_vld_o) && $stable(od_vld_o) &&
                 $stable(ev_addr_o) && $stable(od_addr_o)));
  p_adv_pair_r2: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && adv_o == 2'd2) |=> (ev_vld_o && od_vld_o));
  p_even_class_r9: assert property (@(posedge clk) disable iff (rst)
    ev_vld_o |-> !ev_opc_o[OPC_W-1]);
  p_odd_class_r9: assert property (@(posedge clk) disable iff (rst)
    od_vld_o |-> od_opc_o[OPC_W-1]);
  p_adv_range_r10: assert property (@(posedge clk) disable iff (rst)
    !a_vld_i |-> adv_o == 2'd0);
endmodule

// File: tb/test_dual_issue_pair.sv
module test_dual_issue_pair;
  localparam int AW   = 12;
  localparam int NREG = 32;
  localparam int RW   = $clog2(NREG);
  localparam int MAXP = 48;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst, stall_i;
  logic            a_vld_i, b_vld_i;
  logic [AW-1:0]   a_addr_i, b_addr_i;
  logic [3:0]      a_opc_i, b_opc_i;
  logic [RW-1:0]   a_dst_i, b_dst_i;
  logic [3*RW-1:0] a_src_i, b_src_i;
  logic [2:0]      a_sen_i, b_sen_i;
  logic [1:0]      adv_o;
  logic            ev_vld_o, od_vld_o;
  logic [3:0]      ev_opc_o, od_opc_o;
  logic [RW-1:0]   ev_dst_o, od_dst_o;
  logic [AW-1:0]   ev_addr_o, od_addr_o;

  dual_issue_pair #(.AW(AW), .NREG(NREG)) i_dual_issue_pair (.*);

  typedef struct packed {
    logic ev_v; logic [3:0] ev_op; logic [RW-1:0] ev_d; logic [AW-1:0] ev_a;
    logic od_v; logic [3:0] od_op; logic [RW-1:0] od_d; logic [AW-1:0] od_a;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;

  logic [3:0]    p_opc [MAXP];
  logic [RW-1:0] p_dst [MAXP];
  logic [RW-1:0] p_src [MAXP][3];
  logic [2:0]    p_sen [MAXP];
  int n = 0;
  int busy [NREG];

  task automatic add_i(input int opc, input int dst, input int s0, input int s1,
                       input int s2, input int sen);
    p_opc[n] = 4'(opc); p_dst[n] = RW'(dst);
    p_src[n][0] = RW'(s0); p_src[n][1] = RW'(s1); p_src[n][2] = RW'(s2);
    p_sen[n] = 3'(sen);
    n++;
  endtask

  function automatic obs_t actual();
    obs_t o;
    o = '0;
    if (ev_vld_o) begin o.ev_v = 1; o.ev_op = ev_opc_o; o.ev_d = ev_dst_o; o.ev_a = ev_addr_o; end
    if (od_vld_o) begin o.od_v = 1; o.od_op = od_opc_o; o.od_d = od_dst_o; o.od_a = od_addr_o; end
    return o;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: compare registered issue ports with the queued expectation
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      obs_t e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = actual();
      check(a == e, t, "issue ports", 64'(a), 64'(e));
    end
  end

  function automatic bit src_busy(input int i);
    bit b = 0;
    for (int k = 0; k < 3; k++) if (p_sen[i][k] && busy[p_src[i][k]] > 0) b = 1;
    return b;
  endfunction

  function automatic obs_t put(input obs_t o, input int i, input bit odd);
    if (odd) begin o.od_v = 1; o.od_op = p_opc[i]; o.od_d = p_dst[i]; o.od_a = AW'(i); end
    else     begin o.ev_v = 1; o.ev_op = p_opc[i]; o.ev_d = p_dst[i]; o.ev_a = AW'(i); end
    return o;
  endfunction

  initial begin
    int pc, cyc, tail, eadv;
    bit ia, ib, raw;
    string tg;
    obs_t last, cur;

    // program (address = index)
    add_i(0, 1, 0, 0, 0, 0);      // 0 even pipe
    add_i(8, 2, 0, 0, 0, 0);      // 1 odd pipe -> pair
    add_i(9, 3, 0, 0, 0, 0);      // 2 odd pipe at even address
    add_i(1, 4, 0, 0, 0, 0);      // 3 even pipe at odd address
    add_i(2, 5, 0, 0, 0, 0);      // 4 latency 4
    add_i(10, 6, 5, 0, 0, 1);     // 5 reads 5
    add_i(0, 7, 0, 6, 0, 2);      // 6 reads 6 via src1
    add_i(8, 8, 0, 0, 0, 0);      // 7
    add_i(0, 9, 0, 0, 0, 0);      // 8
    add_i(8, 9, 0, 0, 0, 0);      // 9 same destination
    add_i(3, 10, 9, 9, 9, 0);     // 10 disabled sources name busy reg
    add_i(11, 11, 0, 0, 0, 0);    // 11
    add_i(4, 12, 1, 0, 0, 1);     // 12
    add_i(12, 13, 0, 0, 12, 4);   // 13 reads 12 via src2
    for (int i = 14; i < 30; i++)
      add_i((i * 7) % 16, 16 + (i % 10), 16 + ((i + 3) % 10), 0, 0, (i % 3 == 0) ? 1 : 0);

    foreach (busy[r]) busy[r] = 0;
    rst = 1; stall_i = 0;
    a_vld_i = 0; a_addr_i = '0; a_opc_i = '0; a_dst_i = '0; a_src_i = '0; a_sen_i = '0;
    b_vld_i = 0; b_addr_i = '0; b_opc_i = '0; b_dst_i = '0; b_src_i = '0; b_sen_i = '0;
    repeat (3) @(negedge clk);
    check(!ev_vld_o && !od_vld_o, "R1", "strobes in reset", 64'({ev_vld_o, od_vld_o}), 64'(0));
    check(adv_o == 0, "R1", "adv in reset", 64'(adv_o), 64'(0));
    rst = 0;
    last = '0;
    pc = 0; cyc = 0; tail = 0;

    while (cyc < 600 && tail < 3) begin
      @(negedge clk);
      stall_i = (cyc == 5 || cyc == 6 || cyc == 15);
      a_vld_i = (pc < n);
      b_vld_i = (pc + 1 < n);
      if (pc < n) begin
        a_addr_i = AW'(pc); a_opc_i = p_opc[pc]; a_dst_i = p_dst[pc];
        a_src_i = {p_src[pc][2], p_src[pc][1], p_src[pc][0]}; a_sen_i = p_sen[pc];
      end
      if (pc + 1 < n) begin
        b_addr_i = AW'(pc + 1); b_opc_i = p_opc[pc + 1]; b_dst_i = p_dst[pc + 1];
        b_src_i = {p_src[pc+1][2], p_src[pc+1][1], p_src[pc+1][0]}; b_sen_i = p_sen[pc + 1];
      end
      #1;
      ia = 0; ib = 0; tg = "R10";
      if (stall_i) begin
        tg = "R8";
      end else if (pc < n) begin
        if (src_busy(pc)) tg = "R6";
        else if (busy[p_dst[pc]] > 0) tg = "R7";
        else begin
          ia = 1;
          if (pc % 2 == 1) tg = "R4";
          else if (pc + 1 >= n) tg = "R9";
          else if (p_opc[pc][3] != 0 || p_opc[pc + 1][3] != 1) tg = "R3";
          else begin
            raw = 0;
            for (int k = 0; k < 3; k++)
              if (p_sen[pc + 1][k] && p_src[pc + 1][k] == p_dst[pc]) raw = 1;
            if (raw || p_dst[pc + 1] == p_dst[pc]) tg = "R5";
            else if (src_busy(pc + 1) || busy[p_dst[pc + 1]] > 0) tg = "R6";
            else begin ib = 1; tg = "R2"; end
          end
        end
      end
      eadv = ia + ib;
      check(adv_o == 2'(eadv), tg, "adv", 64'(adv_o), 64'(eadv));
      if (!stall_i) begin
        cur = '0;
        if (ib) begin cur = put(cur, pc, 0); cur = put(cur, pc + 1, 1); end
        else if (ia) cur = put(cur, pc, p_opc[pc][3]);
        last = cur;
      end
      exp_q.push_back(last);
      tag_q.push_back(ia && !ib ? "R9" : tg);
      for (int r = 0; r < NREG; r++) if (busy[r] > 0) busy[r]--;
      if (ia) busy[p_dst[pc]] = 2 + p_opc[pc][1:0];
      if (ib) busy[p_dst[pc + 1]] = 2 + p_opc[pc + 1][1:0];
      pc += eadv;
      if (pc >= n) tail++;
      cyc++;
    end
    @(negedge clk);
    check(pc == n, "R10", "all instructions issued once", 64'(pc), 64'(n));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule